// File: doc/BRIEF.md
# Single-Cycle 8-bit Load/Store Processor Core

This block is a small processor that completes one 24-bit instruction in every clock cycle. Each instruction word has the same layout: a 4-bit operation code, two 4-bit source register selectors (first and second), a 4-bit destination selector and an 8-bit immediate. The core holds an 8-bit program counter and sixteen 8-bit registers. It has an arithmetic/logic unit and a unit that picks the next program counter. Only the load and store operations reach data memory.

The instruction memory sits outside the core and is read combinationally. The program counter addresses it one word per step, and the selected word comes back on `imem_data`. The data memory also sits outside the core. It is a 256-byte store addressed by byte: reads are combinational and writes take effect on the clock edge. Three debug outputs carry the program counter and the two values read from the register file, so a board can show them on LEDs or digits.

Top module: `byte_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and clears all sixteen registers. While the reset state holds and a no-op is presented, `dmem_we` is low.
- R2: The instruction word has these fields: opcode [23:20], first source A [19:16], second source B [15:12], destination D [11:8] and immediate [7:0]. Opcode 1 writes A+B into D, 2 writes A−B, 3 writes A AND B, 4 writes A OR B and 5 writes A XOR B. All results are taken modulo 256 and written on the clock edge.
- R3: Opcode 6 writes A + immediate into D, modulo 256.
- R4: Opcode 7 drives `dmem_addr` with A + immediate (modulo 256) and writes `dmem_rdata` into D in the same cycle.
- R5: Opcode 8 drives `dmem_addr` with A + immediate, drives `dmem_wdata` with B and raises `dmem_we`, and it writes no register. `dmem_we` is high for opcode 8 only.
- R6: Opcode 9 loads the program counter with the immediate when A equals B. Otherwise the program counter advances by one.
- R7: Opcode 10 loads the program counter with A + immediate, modulo 256.
- R8: Every instruction that is not taken as a branch or jump advances the program counter by one, and the count wraps from 255 to 0.
- R9: Opcode 0 and opcodes 11 to 15 change no register and no memory location.
- R10: Register 0 is an ordinary register that can be written and read back.
- R11: `dbg_pc` and `imem_addr` both equal the program counter. `dbg_ra_val` and `dbg_rb_val` carry the current contents of the registers that fields A and B select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction word address (the program counter) |
| imem_data | input | 24 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data memory byte address |
| dmem_wdata | output | 8 | Store data |
| dmem_we | output | 1 | Store enable, sampled on the rising edge |
| dmem_rdata | input | 8 | Combinational read data at `dmem_addr` |
| dbg_pc | output | 8 | Program counter, for display |
| dbg_ra_val | output | 8 | Value read through source port A |
| dbg_rb_val | output | 8 | Value read through source port B |

## Verification
The bench builds the core with its default parameters: 8-bit data, sixteen registers and an 8-bit program counter. With those values the edge cases are easy to reach. A jump with register plus immediate can run past 255 and wrap, a branch can land on an address far away, and an ordinary increment wraps from 255 back to 0, all within a few instructions. The bench feeds in one instruction at a time. After each edge it presents a probe no-op whose A and B fields select the register under test, and it reads that register back through the debug outputs.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int XLEN    = 8;
  localparam int RIDX_W  = 4;
  localparam int OPC_W   = 4;
  localparam int IMM_W   = XLEN;
  localparam int INSTR_W = OPC_W + 3 * RIDX_W + IMM_W;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_AND   = 4'd3,
    OP_OR    = 4'd4,
    OP_XOR   = 4'd5,
    OP_ADDI  = 4'd6,
    OP_LOAD  = 4'd7,
    OP_STORE = 4'd8,
    OP_BEQ   = 4'd9,
    OP_JMPI  = 4'd10
  } opcode_e;

  typedef struct packed {
    logic [OPC_W-1:0]  op;
    logic [RIDX_W-1:0] sa;
    logic [RIDX_W-1:0] sb;
    logic [RIDX_W-1:0] dst;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  // Modulo-2^XLEN sum, shared by the memory address path and the jump path
  function automatic logic [XLEN-1:0] wrap_add(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return XLEN'(a + b);
  endfunction

  // Result of a register-writing arithmetic/logic operation
  function automatic logic [XLEN-1:0] alu_eval(input logic [OPC_W-1:0] op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input logic [XLEN-1:0] imm);
    case (op)
      OP_ADD:  return wrap_add(a, b);
      OP_SUB:  return XLEN'(a - b);
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_ADDI: return wrap_add(a, imm);
      default: return '0;
    endcase
  endfunction

  // True for the operations whose ALU result goes to the destination register
  function automatic logic alu_writes(input logic [OPC_W-1:0] op);
    return (op >= OP_ADD) && (op <= OP_ADDI);
  endfunction
endpackage

// File: rtl/bc_regfile.sv
module bc_regfile #(
  parameter int W = 8,
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr_a,
  input  logic [$clog2(N)-1:0] raddr_b,
  output logic [W-1:0]         rdata_a,
  output logic [W-1:0]         rdata_b
);
  localparam int AW = $clog2(N);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) regs[k] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  logic [AW-1:0] last_waddr;
  always_ff @(posedge clk) last_waddr <= waddr;

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> (regs[last_waddr] == $past(wdata))); // R2
endmodule

// File: rtl/bc_alu.sv
module bc_alu
  import bc_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [XLEN-1:0]  imm,
  output logic [XLEN-1:0]  result,
  output logic             writes_dst
);
  assign result     = alu_eval(op, a, b, imm);
  assign writes_dst = alu_writes(op);

  always_comb begin
    if (op == OP_SUB)
      AST_SUB_INVERTS: assert (XLEN'(result + b) == a); // R2
    if (op == OP_ADDI)
      AST_ADDI_INVERTS: assert (XLEN'(result - imm) == a); // R3
  end
endmodule

// File: rtl/bc_nextpc.sv
module bc_nextpc
  import bc_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic [OPC_W-1:0] op,
  input  logic [PC_W-1:0]  pc,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [IMM_W-1:0] imm,
  output logic [PC_W-1:0]  next_pc,
  output logic             redirect
);
  logic beq_hit;
  logic [PC_W-1:0] jump_target;

  assign beq_hit     = (op == OP_BEQ) && (a == b);
  assign jump_target = PC_W'(wrap_add(a, imm));

  always_comb begin
    redirect = 1'b0;
    next_pc  = PC_W'(pc + 1'b1);
    if (beq_hit) begin
      redirect = 1'b1;
      next_pc  = PC_W'(imm);
    end else if (op == OP_JMPI) begin
      redirect = 1'b1;
      next_pc  = jump_target;
    end
  end
endmodule

// File: rtl/byte_core.sv
module byte_core
  import bc_pkg::*;
#(
  parameter int NREGS = 16,
  parameter int PC_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic [XLEN-1:0]    dmem_addr,
  output logic [XLEN-1:0]    dmem_wdata,
  output logic               dmem_we,
  input  logic [XLEN-1:0]    dmem_rdata,
  output logic [PC_W-1:0]    dbg_pc,
  output logic [XLEN-1:0]    dbg_ra_val,
  output logic [XLEN-1:0]    dbg_rb_val
);
  instr_t          ins;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [XLEN-1:0] a_val, b_val, alu_res, wb_val, mem_addr;
  logic            alu_we, is_load, is_store, rf_we, pc_redirect;

  assign ins      = instr_t'(imem_data);
  assign is_load  = (ins.op == OP_LOAD);
  assign is_store = (ins.op == OP_STORE);

  bc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(ins.dst), .wdata(wb_val),
    .raddr_a(ins.sa), .raddr_b(ins.sb), .rdata_a(a_val), .rdata_b(b_val)
  );

  bc_alu u_alu (
    .op(ins.op), .a(a_val), .b(b_val), .imm(ins.imm),
    .result(alu_res), .writes_dst(alu_we)
  );

  bc_nextpc #(.PC_W(PC_W)) u_npc (
    .op(ins.op), .pc(pc_q), .a(a_val), .b(b_val), .imm(ins.imm),
    .next_pc(pc_d), .redirect(pc_redirect)
  );

  assign mem_addr = wrap_add(a_val, ins.imm);
  assign rf_we    = alu_we | is_load;
  assign wb_val   = is_load ? dmem_rdata : alu_res;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = mem_addr;
  assign dmem_wdata = b_val;
  assign dmem_we    = is_store;
  assign dbg_pc     = pc_q;
  assign dbg_ra_val = a_val;
  assign dbg_rb_val = b_val;

  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we); // R5
  AST_BEQ_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ins.op == OP_BEQ && a_val == b_val) |=> (pc_q == PC_W'($past(ins.imm)))); // R6
  AST_JMPI_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ins.op == OP_JMPI) |=> (pc_q == PC_W'($past(mem_addr)))); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !pc_redirect |=> (pc_q == PC_W'($past(pc_q) + 1'b1))); // R8
endmodule

// File: tb/sim_byte_core.sv
`timescale 1ns/100ps
module sim_byte_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [7:0]  dbg_pc, dbg_ra_val, dbg_rb_val;
  logic [23:0] cur_instr = 24'h000000;
  logic        dmem_we;
  logic [7:0]  ram [256];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  byte_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(cur_instr),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .dbg_pc(dbg_pc), .dbg_ra_val(dbg_ra_val),
    .dbg_rb_val(dbg_rb_val)
  );

  assign dmem_rdata = ram[dmem_addr];
  always @(posedge clk) if (dmem_we) ram[dmem_addr] <= dmem_wdata;

  // {instruction, expected PC after, register to probe, expected value}
  localparam logic [43:0] VEC [18] = '{
    {24'h600105, 8'h01, 4'h1, 8'h05},
    {24'h6102FE, 8'h02, 4'h2, 8'h03},
    {24'h112300, 8'h03, 4'h3, 8'h08},
    {24'h221400, 8'h04, 4'h4, 8'hFE},
    {24'h314500, 8'h05, 4'h5, 8'h04},
    {24'h412600, 8'h06, 4'h6, 8'h07},
    {24'h514700, 8'h07, 4'h7, 8'hFB},
    {24'h813010, 8'h08, 4'h0, 8'h00},
    {24'h710810, 8'h09, 4'h8, 8'h08},
    {24'h912040, 8'h0A, 4'h1, 8'h05},
    {24'h938040, 8'h40, 4'h3, 8'h08},
    {24'hA40005, 8'h03, 4'h4, 8'hFE},
    {24'hF11177, 8'h04, 4'h1, 8'h05},
    {24'h0012FF, 8'h05, 4'h2, 8'h03},
    {24'h610001, 8'h06, 4'h0, 8'h06},
    {24'hA000F9, 8'hFF, 4'h0, 8'h06},
    {24'h000000, 8'h00, 4'h0, 8'h06},
    {24'hB22233, 8'h01, 4'h2, 8'h03}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 14: return "R10";
      1:     return "R3";
      7:     return "R5";
      8:     return "R4";
      9, 10: return "R6";
      11, 15: return "R7";
      12, 13, 17: return "R9";
      16:    return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic probe(input logic [3:0] r);
    cur_instr = {4'h0, r, r, 4'h0, 8'h00};
    #1;
  endtask

  initial begin
    for (int k = 0; k < 256; k++) ram[k] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    probe(4'h5);
    check(dbg_pc == 8'h00, "R1", "pc after reset", dbg_pc, 8'h00);
    check(dbg_ra_val == 8'h00, "R1", "reg after reset", dbg_ra_val, 8'h00);
    check(dmem_we == 1'b0, "R1", "we after reset", dmem_we, 1'b0);

    for (int i = 0; i < 18; i++) begin
      cur_instr = VEC[i][43:20];
      #1;
      check(dmem_we == (VEC[i][43:40] == 4'h8), "R5", "store enable", dmem_we,
            (VEC[i][43:40] == 4'h8));
      if (i == 7) begin
        check(dmem_addr == 8'h15, "R5", "store address", dmem_addr, 8'h15);
        check(dmem_wdata == 8'h08, "R5", "store data", dmem_wdata, 8'h08);
      end
      if (i == 8)
        check(dmem_addr == 8'h15, "R4", "load address", dmem_addr, 8'h15);
      @(posedge clk);
      @(negedge clk);
      probe(VEC[i][11:8]);
      check(dbg_pc == VEC[i][19:12], "R8", "next pc", dbg_pc, VEC[i][19:12]);
      check(imem_addr == dbg_pc, "R11", "fetch address", imem_addr, dbg_pc);
      check(dbg_ra_val == VEC[i][7:0], tag_of(i), "register A", dbg_ra_val, VEC[i][7:0]);
      check(dbg_rb_val == VEC[i][7:0], "R11", "register B", dbg_rb_val, VEC[i][7:0]);
    end

    check(ram[8'h15] == 8'h08, "R5", "stored byte", ram[8'h15], 8'h08);
    check(ram[8'h77] == 8'h00, "R9", "reserved op memory", ram[8'h77], 8'h00);

    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    probe(4'h3);
    check(dbg_pc == 8'h00, "R1", "pc after mid reset", dbg_pc, 8'h00);
    check(dbg_ra_val == 8'h00, "R1", "reg after mid reset", dbg_ra_val, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule